// File: doc/BRIEF.md
# TDM bi-phase mark line encoder

This block combines two serial channels onto one line signal. Channel A carries a single trigger bit per basic clock period. Channel B carries one bit of a serial command or address/data stream per period. Each basic period is split into two bit cells, A first and B second, so the multiplexed stream runs at twice the basic rate. Each cell is then bi-phase mark coded: the line changes level at the start of every cell, and changes again at the middle of the cell only when the bit is 1. The coded bit is produced at four times the basic rate.

Everything runs on one fast clock at four times the basic rate. A free-running two-bit phase counter sets the cell timing. The block exports a one-cycle strobe, one per basic period, so that the channel source and any decoder can lock to the period boundaries. Because all timing comes from clock ratios, the design works for any basic frequency the surrounding clock system delivers. The asynchronous active-low reset is released through a short synchronizer.

Top module: `tdm_bpm_encoder`

## Requirements
- R1: While `rst_n` is low, `line_o` and `bc_stb_o` are 0, and they go to 0 without waiting for a clock edge.
- R2: `bc_stb_o` is high for exactly one cycle in every four. It marks the cycle in which `line_o` shows the first half of the A cell. Calling that cycle 0, cycles 0 and 1 carry the A cell and cycles 2 and 3 carry the B cell.
- R3: `line_o` changes level at the start of every bit cell: between cycle 3 of one period and cycle 0 of the next, and between cycles 1 and 2.
- R4: Between cycles 0 and 1, `line_o` changes level if and only if the A bit sent in that period is 1.
- R5: Between cycles 2 and 3, `line_o` changes level if and only if the B bit sent in that period is 1.
- R6: Both inputs are captured only at the clock edge that ends cycle 2. The pair captured there is sent in the period that starts with the next strobe. Input values present at every other edge have no effect on `line_o`.
- R7: The first period after reset release sends A=0 and B=0, whatever the inputs are. Its first half-cell drives `line_o` from 0 to 1.
- R8: With the default two synchronizer stages, the first strobe is high in the cycle that follows the third rising clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at four times the basic rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_a | input | 1 | Channel A trigger bit, one per basic period |
| chan_b | input | 1 | Channel B serial command/data bit, one per basic period |
| line_o | output | 1 | Bi-phase mark coded line signal |
| bc_stb_o | output | 1 | One-cycle strobe at the start of each basic period |

## Verification
The assertions assume that the inputs hold known values at the capture edge, and that the phase counter starts counting only after the synchronized reset is released. They do not assume that the inputs stay stable for the rest of the period. The stimulus changes the inputs only on falling clock edges and times every change from `bc_stb_o`. In part of the run it drives the inverted pair during the non-capture cycles and the true pair only across the capture edge, which confirms that the capture point is the only one that matters. A reference decoder in the bench locks to the strobe and recovers A and B from the mid-cell transitions. It covers all four A/B combinations, a pseudo-random stream and a reset applied in the middle of a period.

// File: rtl/tdm_bpm_pkg.sv
package tdm_bpm_pkg;
  // four fast cycles per basic period: two cells of two halves each
  localparam int unsigned PH_W = 2;
  localparam int unsigned N_CH = 2;
  typedef logic [PH_W-1:0] phase_t;
  typedef logic [N_CH-1:0] chan_vec_t;
  // channel index: 0 = A (first cell), 1 = B (second cell)
  localparam phase_t PH_FIRST  = phase_t'(0);
  localparam phase_t PH_SAMPLE = phase_t'((1 << PH_W) - 1);
endpackage

// File: rtl/tdm_rst_sync.sv
module tdm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = (sh_q << 1) | STAGES'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/tdm_phase_gen.sv
module tdm_phase_gen
  import tdm_bpm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t ph,
  output logic   sample_en,
  output logic   bc_stb
);
  phase_t ph_q, ph_d;
  logic   stb_q, stb_d;

  always_comb begin
    ph_d  = ph_q + 1'b1;
    stb_d = (ph_q == PH_FIRST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_FIRST;
      stb_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      stb_q <= stb_d;
    end
  end

  assign ph        = ph_q;
  assign sample_en = (ph_q == PH_SAMPLE);
  assign bc_stb    = stb_q;

  // R2: the strobe never lasts two cycles
  p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  // R2: the strobe coincides with the line showing the A first half
  p_stb_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> ph_q == phase_t'(PH_FIRST + 1'b1));
endmodule

// File: rtl/tdm_chan_sampler.sv
module tdm_chan_sampler
  import tdm_bpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sample_en,
  input  chan_vec_t ch_in,
  output chan_vec_t ch_hold
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic q, d;
    always_comb begin
      d = sample_en ? ch_in[g] : q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign ch_hold[g] = q;
  end

  // R6: held bits change only across the capture edge
  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(ch_hold));
endmodule

// File: rtl/bpm_line_coder.sv
module bpm_line_coder
  import tdm_bpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  phase_t    ph,
  input  chan_vec_t bits,
  output logic      line
);
  logic line_q, line_d, cur_bit, flip;

  always_comb begin
    cur_bit = bits[ph[PH_W-1]];
    flip    = ~ph[0] | cur_bit;
    line_d  = line_q ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  assign line = line_q;

  // R3: every cell begins with a level change
  p_cell_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == phase_t'(0) || ph == phase_t'(2)) |=> line_q != $past(line_q));
  // R4: A cell midpoint follows the A bit
  p_mid_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == phase_t'(1)) |=> (line_q != $past(line_q)) == $past(bits[0]));
  // R5: B cell midpoint follows the B bit
  p_mid_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == phase_t'(3)) |=> (line_q != $past(line_q)) == $past(bits[1]));
endmodule

// File: rtl/tdm_bpm_encoder.sv
module tdm_bpm_encoder
  import tdm_bpm_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_a,
  input  logic chan_b,
  output logic line_o,
  output logic bc_stb_o
);
  logic      rst_sync_n;
  phase_t    ph;
  logic      sample_en;
  chan_vec_t held;

  tdm_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tdm_phase_gen u_phase_gen (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ph        (ph),
    .sample_en (sample_en),
    .bc_stb    (bc_stb_o)
  );

  tdm_chan_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sample_en (sample_en),
    .ch_in     ({chan_b, chan_a}),
    .ch_hold   (held)
  );

  bpm_line_coder u_coder (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ph    (ph),
    .bits  (held),
    .line  (line_o)
  );
endmodule

// File: tb/tdm_bpm_encoder_bench.sv
module tdm_bpm_encoder_bench;
  logic clk;
  logic rst_n;
  logic chan_a, chan_b;
  logic line_o, bc_stb_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic       prev_lvl;
  logic [1:0] exp_w;
  bit         exp_glitched;
  logic [15:0] lfsr;

  // {A,B} pairs
  localparam logic [1:0] VEC [16] = '{
    2'b00, 2'b10, 2'b01, 2'b11, 2'b00, 2'b11, 2'b10, 2'b10,
    2'b01, 2'b01, 2'b11, 2'b11, 2'b00, 2'b00, 2'b10, 2'b01 };

  tdm_bpm_encoder u_tdm_bpm_encoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_a   (chan_a),
    .chan_b   (chan_b),
    .line_o   (line_o),
    .bc_stb_o (bc_stb_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] w);
    chan_a = w[1];
    chan_b = w[0];
  endtask

  // called at the falling edge of a strobe cycle; decodes the current
  // period against exp_w and loads nxt for the following period
  task automatic run_period(input logic [1:0] nxt, input bit glitch);
    logic h0, h1, h2, h3;
    int   stb_mid;
    h0 = line_o;
    drive(glitch ? ~nxt : nxt);
    @(negedge clk); h1 = line_o; stb_mid = int'(bc_stb_o);
    @(negedge clk); h2 = line_o; stb_mid += int'(bc_stb_o);
    drive(nxt);
    @(negedge clk); h3 = line_o; stb_mid += int'(bc_stb_o);
    if (glitch) drive(~nxt);
    check("R2", "strobe inside period", stb_mid, 0);
    check("R3", "A cell start edge", int'(h0 != prev_lvl), 1);
    check("R3", "B cell start edge", int'(h2 != h1), 1);
    check(exp_glitched ? "R6" : "R4", "decoded A", int'(h0 != h1), int'(exp_w[1]));
    check(exp_glitched ? "R6" : "R5", "decoded B", int'(h2 != h3), int'(exp_w[0]));
    prev_lvl     = h3;
    exp_w        = nxt;
    exp_glitched = glitch;
    @(negedge clk);
    check("R2", "strobe at period start", int'(bc_stb_o), 1);
  endtask

  // release reset at a falling edge and follow the first strobe
  task automatic release_and_align();
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8", "no strobe after edge 1", int'(bc_stb_o), 0);
    @(posedge clk); @(negedge clk);
    check("R8", "no strobe after edge 2", int'(bc_stb_o), 0);
    @(posedge clk); @(negedge clk);
    check("R8", "first strobe after edge 3", int'(bc_stb_o), 1);
    check("R7", "first half level", int'(line_o), 1);
    prev_lvl     = 1'b0;
    exp_w        = 2'b00;
    exp_glitched = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(2'b11);
    repeat (3) begin
      @(negedge clk);
      check("R1", "line in reset", int'(line_o), 0);
      check("R1", "strobe in reset", int'(bc_stb_o), 0);
    end
    // inputs held high during reset must not reach the first period (R7)
    release_and_align();
    for (int i = 0; i < 16; i++) run_period(VEC[i], 1'b0);
    run_period(2'b00, 1'b0);

    // pseudo-random stream, inputs inverted outside the capture edge (R6)
    lfsr = 16'hACE1;
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_period(lfsr[1:0], 1'b1);
    end
    run_period(2'b11, 1'b0);

    // reset in the middle of a period while the line is high (R1)
    while (line_o !== 1'b1) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "line cleared without clock", int'(line_o), 0);
    check("R1", "strobe cleared without clock", int'(bc_stb_o), 0);
    drive(2'b11);
    @(negedge clk);
    release_and_align();
    run_period(2'b11, 1'b0);   // R7: first period still 0/0
    run_period(2'b01, 1'b0);   // 1/1 expected here
    run_period(2'b00, 1'b0);   // 0/1 expected here

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule